// File: doc/BRIEF.md
# RTC Update Cycle Sequencer

This block keeps the calendar of a real-time clock and advances it once per second. A single-cycle tick at the 32.768 kHz timebase rate drives a prescaler. When the prescaler wraps, the block raises an update-in-progress flag. A fixed number of ticks later it applies the whole carry chain in one clock: seconds, minutes, hours, day of month, month and year. The flag then stays up for a further fixed number of ticks. When the flag drops, the block pulses an update-ended event toward the interrupt logic.

Software reaches the fields through a small register port. Writes take effect on the next clock edge, and reads are combinational. A mode register holds three controls. The freeze bit stops updates so the time can be loaded safely. The number-format bit selects binary or packed BCD fields. The hour-format bit selects a 24-hour clock, or a 12-hour clock that carries an afternoon marker in the top bit of the hour field. If a BCD year above 99 is found during an update, the date is rewritten to a default. A status register always reports valid contents and mirrors the update flag.

Top module: `rtc_update_seq`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01 and year 0x00. The mode register at address 6 reads 0x02, `uip` is 0 and the status at address 7 reads 0x80. The address map is 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 mode, 7 status.
- R2: `uip` rises on the clock edge where the prescaler completes TICKS_PER_SEC ticks. The time fields change on the LEAD_TICKS-th tick after that rise.
- R3: `uip` falls on the (LEAD_TICKS+UPDATE_TICKS)-th tick after its rise. On that same edge `upd_end` goes high, and it stays high for exactly one clock.
- R4: While mode bit 7 (freeze) is 1, `uip` stays 0 and no field advances.
- R5: With mode bit 2 at 0, every field is packed BCD (tens in bits 7:4, units in bits 3:0). Seconds and minutes wrap from 0x59 to 0x00 and carry onward.
- R6: With mode bit 2 at 1, every field is a plain binary value with the same wrap points.
- R7: With mode bit 1 at 1 (24-hour), hours wrap from 23 to 0 and carry into the day.
- R8: With mode bit 1 at 0 (12-hour), hours run 12, 1 … 11. Bit 7 of the hour field marks afternoon and toggles on the step from 11 to 12. The day advances on the step from 11 PM to 12 AM.
- R9: The day wraps to 1 after 30 in April, June, September and November, and after 31 in the other long months. In February it wraps after 29 when the year is a multiple of 4, and after 28 otherwise.
- R10: Month 12 wraps to 1 and increments the year. Year 99 wraps to 0.
- R11: In BCD mode, an update that finds a raw year value above 0x99 sets day 0x01, month 0x01 and year 0x00. Seconds, minutes and hours still advance normally.
- R12: Status bit 7 always reads 1, and status bit 0 mirrors `uip`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock pulse per timebase period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| uip | output | 1 | Update-in-progress flag |
| upd_end | output | 1 | One-clock update-ended event |

## Verification
The bench builds the block with TICKS_PER_SEC=16, LEAD_TICKS=2 and UPDATE_TICKS=3, and pulses `tick` every fourth clock. A simulated second therefore lasts 64 clocks. That puts year, month and leap-day rollovers within a few hundred cycles each. It also lets the lead and tail of the flag window be checked at exact clock offsets, 8 and 20 clocks after the rise.

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int LEAD_TICKS    = 8,
  parameter int UPDATE_TICKS  = 65,
  localparam int DW = $clog2(TICKS_PER_SEC),
  localparam int WW = $clog2(LEAD_TICKS + UPDATE_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       uip,
  output logic       upd_end
);

  logic [DW-1:0] div_q;
  logic [WW-1:0] win_q;
  logic          uip_q, end_q;
  logic          set_q, bin_q, h24_q;
  logic [7:0]    sec_q, min_q, hr_q, day_q, mon_q, yr_q;

  function automatic logic [6:0] dec(input logic [7:0] v, input logic b);
    return b ? v[6:0] : 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] v, input logic b);
    return b ? {1'b0, v} : {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [6:0] mdays(input logic [6:0] mo, input logic leap);
    case (mo)
      7'd2:                       return leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
      default:                    return 7'd31;
    endcase
  endfunction

  wire sec_edge = tick && div_q == DW'(TICKS_PER_SEC - 1);
  wire carry    = uip_q && tick && !set_q && win_q == WW'(LEAD_TICKS - 1);
  wire win_done = uip_q && tick && win_q == WW'(LEAD_TICKS + UPDATE_TICKS - 1);

  wire [6:0] sv  = dec(sec_q, bin_q);
  wire [6:0] mv  = dec(min_q, bin_q);
  wire [6:0] hv  = h24_q ? dec(hr_q, bin_q) : dec({1'b0, hr_q[6:0]}, bin_q);
  wire [6:0] dv  = dec(day_q, bin_q);
  wire [6:0] mov = dec(mon_q, bin_q);
  wire [6:0] yv  = dec(yr_q, bin_q);
  wire       pm  = hr_q[7];
  wire       year_bad = !bin_q && yr_q > 8'h99;
  wire       s_wrap = sv >= 7'd59;
  wire       m_wrap = s_wrap && mv >= 7'd59;

  logic [7:0] n_sec, n_min, n_hr, n_day, n_mon, n_yr, htmp;
  logic       day_c;

  always_comb begin
    n_sec = enc(s_wrap ? 7'd0 : sv + 7'd1, bin_q);
    n_min = s_wrap ? enc(m_wrap ? 7'd0 : mv + 7'd1, bin_q) : min_q;
    n_hr  = hr_q;
    htmp  = 8'h00;
    day_c = 1'b0;
    if (m_wrap) begin
      if (h24_q) begin
        day_c = hv >= 7'd23;
        n_hr  = enc(day_c ? 7'd0 : hv + 7'd1, bin_q);
      end else if (hv >= 7'd12) begin
        htmp = enc(7'd1, bin_q);
        n_hr = {pm, htmp[6:0]};
      end else if (hv == 7'd11) begin
        htmp  = enc(7'd12, bin_q);
        n_hr  = {~pm, htmp[6:0]};
        day_c = pm;
      end else begin
        htmp = enc(hv + 7'd1, bin_q);
        n_hr = {pm, htmp[6:0]};
      end
    end
    n_day = day_q;
    n_mon = mon_q;
    n_yr  = yr_q;
    if (year_bad) begin
      n_day = 8'h01;
      n_mon = 8'h01;
      n_yr  = 8'h00;
    end else if (day_c) begin
      if (dv >= mdays(mov, yv[1:0] == 2'b00)) begin
        n_day = enc(7'd1, bin_q);
        if (mov >= 7'd12) begin
          n_mon = enc(7'd1, bin_q);
          n_yr  = enc(yv >= 7'd99 ? 7'd0 : yv + 7'd1, bin_q);
        end else begin
          n_mon = enc(mov + 7'd1, bin_q);
        end
      end else begin
        n_day = enc(dv + 7'd1, bin_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      win_q <= '0;
      uip_q <= 1'b0;
      end_q <= 1'b0;
    end else begin
      if (tick) div_q <= sec_edge ? '0 : div_q + 1'b1;
      end_q <= 1'b0;
      if (set_q) begin
        uip_q <= 1'b0;
        win_q <= '0;
      end else if (sec_edge && !uip_q) begin
        uip_q <= 1'b1;
        win_q <= '0;
      end else if (uip_q && tick) begin
        win_q <= win_q + 1'b1;
        if (win_done) begin
          uip_q <= 1'b0;
          end_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {sec_q, min_q, hr_q} <= '0;
      day_q <= 8'h01;
      mon_q <= 8'h01;
      yr_q  <= 8'h00;
      set_q <= 1'b0;
      bin_q <= 1'b0;
      h24_q <= 1'b1;
    end else begin
      if (carry) begin
        sec_q <= n_sec;
        min_q <= n_min;
        hr_q  <= n_hr;
        day_q <= n_day;
        mon_q <= n_mon;
        yr_q  <= n_yr;
      end
      if (wr_en) begin
        case (addr)
          4'd0: sec_q <= wdata;
          4'd1: min_q <= wdata;
          4'd2: hr_q  <= wdata;
          4'd3: day_q <= wdata;
          4'd4: mon_q <= wdata;
          4'd5: yr_q  <= wdata;
          4'd6: {set_q, bin_q, h24_q} <= {wdata[7], wdata[2], wdata[1]};
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      4'd0:    rdata = sec_q;
      4'd1:    rdata = min_q;
      4'd2:    rdata = hr_q;
      4'd3:    rdata = day_q;
      4'd4:    rdata = mon_q;
      4'd5:    rdata = yr_q;
      4'd6:    rdata = {set_q, 4'b0000, bin_q, h24_q, 1'b0};
      4'd7:    rdata = {1'b1, 6'b000000, uip_q};
      default: rdata = 8'h00;
    endcase
  end

  assign uip     = uip_q;
  assign upd_end = end_q;

endmodule

module rtc_update_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic       uip,
  input logic       upd_end,
  input logic       set_q,
  input logic [7:0] sec_q
);
  // R3
  end_after_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end |-> !uip && $past(uip));
  // R3
  end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end |=> !upd_end);
  // R4
  freeze_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_q |=> !uip);
  // R2
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> $past(tick));
  // R2
  sec_moves_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sec_q) && !$past(wr_en) |-> $past(uip) && $past(tick));
endmodule

bind rtc_update_seq rtc_update_seq_chk chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
  .uip(uip), .upd_end(upd_end), .set_q(set_q), .sec_q(sec_q)
);

// File: tb/tb_rtc_update_seq.sv
module tb_rtc_update_seq;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic uip, upd_end;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  rtc_update_seq #(.TICKS_PER_SEC(16), .LEAD_TICKS(2), .UPDATE_TICKS(3)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .uip(uip), .upd_end(upd_end));

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_end();
    do @(negedge clk); while (!upd_end);
  endtask

  task automatic load(logic [7:0] mode, logic [7:0] y, logic [7:0] mo,
                      logic [7:0] d, logic [7:0] h, logic [7:0] m, logic [7:0] s);
    wr(4'd6, mode | 8'h80);
    wr(4'd5, y); wr(4'd4, mo); wr(4'd3, d);
    wr(4'd2, h); wr(4'd1, m); wr(4'd0, s);
    wr(4'd6, mode);
    wait_end();
  endtask

  task automatic expect_all(string req, logic [7:0] y, logic [7:0] mo,
                            logic [7:0] d, logic [7:0] h, logic [7:0] m, logic [7:0] s);
    logic [7:0] v;
    rd(4'd0, v); chk({req, " sec"}, v, s);
    rd(4'd1, v); chk({req, " min"}, v, m);
    rd(4'd2, v); chk({req, " hour"}, v, h);
    rd(4'd3, v); chk({req, " day"}, v, d);
    rd(4'd4, v); chk({req, " month"}, v, mo);
    rd(4'd5, v); chk({req, " year"}, v, y);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    @(negedge clk);
    expect_all("R1", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd(4'd6, v); chk("R1 mode", v, 8'h02);
    rd(4'd7, v); chk("R1 R12 status", v, 8'h80);
    chk("R1 uip", {7'd0, uip}, 8'h00);
  endtask

  task automatic t_window();
    logic [7:0] s0, v;
    do @(negedge clk); while (!uip);
    rd(4'd0, s0);
    rd(4'd7, v); chk("R12 status uip", v, 8'h81);
    addr = 4'd0;
    for (int k = 1; k <= 21; k++) begin
      @(negedge clk);
      #1;
      if (k == 7)  chk("R2 before carry", rdata, s0);
      if (k == 8)  chk("R2 at carry", rdata, s0 + 8'h01);
      if (k == 19) chk("R3 flag held", {6'd0, uip, upd_end}, 8'h02);
      if (k == 20) chk("R3 flag drop", {6'd0, uip, upd_end}, 8'h01);
      if (k == 21) chk("R3 pulse one clock", {7'd0, upd_end}, 8'h00);
    end
  endtask

  task automatic t_binary();
    load(8'h06, 8'd3, 8'd2, 8'd28, 8'd23, 8'd59, 8'd59);
    expect_all("R6 R7 R9 binary", 8'd3, 8'd3, 8'd1, 8'd0, 8'd0, 8'd0);
  endtask

  task automatic t_leap();
    load(8'h02, 8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    expect_all("R5 R9 leap", 8'h24, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_short_month();
    load(8'h02, 8'h21, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    expect_all("R9 April", 8'h21, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_year_wrap();
    load(8'h02, 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    expect_all("R10 year wrap", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_twelve();
    load(8'h00, 8'h10, 8'h03, 8'h05, 8'h11, 8'h59, 8'h59);
    expect_all("R8 noon", 8'h10, 8'h03, 8'h05, 8'h92, 8'h00, 8'h00);
    load(8'h00, 8'h10, 8'h03, 8'h05, 8'h92, 8'h59, 8'h59);
    expect_all("R8 one pm", 8'h10, 8'h03, 8'h05, 8'h81, 8'h00, 8'h00);
    load(8'h00, 8'h10, 8'h03, 8'h05, 8'h91, 8'h59, 8'h59);
    expect_all("R8 midnight", 8'h10, 8'h03, 8'h06, 8'h12, 8'h00, 8'h00);
  endtask

  task automatic t_bad_year();
    load(8'h02, 8'hA5, 8'h07, 8'h15, 8'h08, 8'h30, 8'h10);
    expect_all("R11 bad year", 8'h00, 8'h01, 8'h01, 8'h08, 8'h30, 8'h11);
  endtask

  task automatic t_freeze();
    logic [7:0] s0, v;
    int highs = 0;
    wr(4'd6, 8'h82);
    repeat (2) @(negedge clk);
    rd(4'd0, s0);
    repeat (200) begin
      @(negedge clk);
      if (uip) highs++;
    end
    chk("R4 no flag", 8'(highs), 8'h00);
    rd(4'd0, v); chk("R4 frozen sec", v, s0);
    wr(4'd6, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_window();
    t_binary();
    t_leap();
    t_short_month();
    t_year_wrap();
    t_twelve();
    t_bad_year();
    t_freeze();
    summary();
  end
endmodule